// File: doc/BRIEF.md
# I2C Slave Power-Cycle Recovery Supervisor

This block sits beside an I2C master engine and watches the transfers that the engine runs. A transfer fails when SCL stops making progress: a slave that keeps stretching the clock, or a transfer that never finishes. The supervisor then recovers the slave. It floats the I2C pins, switches the slave's supply off for a fixed time, powers it back up, waits for it to settle, and asks the master to run the transfer again.

Each timeout without a success in between raises a consecutive-failure count. Once the allowed number of retries has been spent and the last one has also timed out, the block stops. It leaves the slave unpowered with the pins floating and holds a permanent failure flag until software clears it or the block is reset. All pins are plain level or pulse signals. There is no data path, so no valid/ready handshake applies. The SCL level is expected already synchronised unless `SYNC_STAGES` is set above zero.

Top module: `i2c_pwr_retry_sup`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pins_hiz`=0, `slave_pwr_en`=1, `retry_req`=0 and `dev_dead`=0. Reset is asynchronous, so a reset during recovery restores power at once.
- R2: Monitoring starts the cycle after `xfer_busy` is seen high in idle. If `TIMEOUT_CYC` monitored cycles in a row pass without a rising edge of `scl_in`, `pins_hiz` goes to 1 in the next cycle. A rising edge inside a monitored cycle restarts the count, including a rise in the last cycle of the window.
- R3: `pins_hiz` is 1 for one cycle with power still on before `slave_pwr_en` falls. Whenever `slave_pwr_en` is 0, `pins_hiz` is 1.
- R4: `slave_pwr_en` stays 0 for exactly `OFF_CYC` cycles. It is then 1 for exactly `SETTLE_CYC` cycles while the pins stay floating.
- R5: After the settle time, if retries remain, `retry_req` is 1 for exactly one cycle with `pins_hiz`=0. Monitoring resumes in the next cycle.
- R6: Every timeout adds one to the failure count. When the count exceeds `MAX_RETRY` at the end of a settle time, `retry_req` stays 0 and the pins stay floating for one cycle. From the next cycle on, `dev_dead`=1, `slave_pwr_en`=0 and `pins_hiz`=1.
- R7: The failed state ignores `xfer_busy`, `xfer_done` and `scl_in`, and leaves only on `fail_clr` or reset. `fail_clr` returns the block to idle in the next cycle, with power on and pins released, and clears the failure count.
- R8: `xfer_done` during monitoring returns the block to idle in the next cycle and clears the failure count. It wins over a timeout in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_busy | input | 1 | Master engine has a transfer under way |
| xfer_done | input | 1 | Pulse: transfer completed successfully |
| scl_in | input | 1 | Sampled SCL bus level |
| fail_clr | input | 1 | Leave the failed state |
| pins_hiz | output | 1 | Force the I2C pin drivers to high impedance |
| slave_pwr_en | output | 1 | Slave supply enable |
| retry_req | output | 1 | One-cycle request to the master to rerun the transfer |
| dev_dead | output | 1 | Permanent device failure |

## Verification
All outputs are decoded from the state register, so each result shows up in the cycle after the edge that changes the state. `pins_hiz` rises in the cycle after the `TIMEOUT_CYC`-th silent monitored cycle. Power falls one cycle later, returns `OFF_CYC` cycles after that, and `retry_req` or the failure path follows `SETTLE_CYC` cycles later. The bench drives inputs and samples outputs on the falling clock edge. It counts edges from the cycle in which `xfer_busy` is first driven and checks each output in every cycle of the power-off and settle windows. It does not wait for an event, so an early or late transition is reported. The boundary pair of an SCL rise in the last cycle of the window, and one a cycle late, pins down the timeout limit exactly.

// File: rtl/i2c_sup_pkg.sv
package i2c_sup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WATCH,
    ST_FLOAT,
    ST_PWR_OFF,
    ST_SETTLE,
    ST_RETRY,
    ST_DEAD
  } sup_state_t;

  // bits needed to hold values 0 .. maxval-1
  function automatic int unsigned span_width(int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval);
  endfunction

endpackage

// File: rtl/sup_scl_rise.sv
module sup_scl_rise #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic rise
);

  logic scl_s;
  logic scl_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign scl_s = scl_in;
    end else begin : g_sync
      logic stage_q [SYNC_STAGES];
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= scl_in;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= stage_q[i-1];
          end
        end
      end
      assign scl_s = stage_q[SYNC_STAGES-1];
    end
  endgenerate

  // an idle bus sits high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_s;
  end

  assign rise = scl_s & ~scl_q;

endmodule

// File: rtl/sup_stall_timer.sv
module sup_stall_timer #(
  parameter int unsigned LIMIT = 1000   // must be >= 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expired
);

  localparam int unsigned W = i2c_sup_pkg::span_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || kick)    cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !kick && (cnt_q == LAST);

  // a rise on SCL always buys a full new window
  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick) |=> !expired); // R2

  // expiry needs an uninterrupted run in the previous cycle
  AST_EXPIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run && !kick)); // R2

endmodule

// File: rtl/sup_dwell_timer.sv
module sup_dwell_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (restart)     count <= '0;
    else if (count != '1) count <= count + 1'b1;
  end

endmodule

// File: rtl/sup_fail_counter.sv
module sup_fail_counter #(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clear,
  output logic exhausted
);

  localparam int unsigned CW = $clog2(MAX_RETRY + 2);
  localparam logic [CW-1:0] TOP = CW'(MAX_RETRY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clear)               cnt_q <= '0;
    else if (bump && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q == TOP);

  AST_EXHAUST_NEEDS_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> $past(bump)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !exhausted); // R7

endmodule

// File: rtl/i2c_pwr_retry_sup.sv
module i2c_pwr_retry_sup #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned OFF_CYC     = 500,
  parameter int unsigned SETTLE_CYC  = 200,
  parameter int unsigned MAX_RETRY   = 3,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_busy,
  input  logic xfer_done,
  input  logic scl_in,
  input  logic fail_clr,
  output logic pins_hiz,
  output logic slave_pwr_en,
  output logic retry_req,
  output logic dev_dead
);
  import i2c_sup_pkg::*;

  localparam int unsigned DWELL_MAX = (OFF_CYC > SETTLE_CYC) ? OFF_CYC : SETTLE_CYC;
  localparam int unsigned DW = span_width(DWELL_MAX);
  localparam logic [DW-1:0] OFF_LAST    = DW'(OFF_CYC - 1);
  localparam logic [DW-1:0] SETTLE_LAST = DW'(SETTLE_CYC - 1);

  sup_state_t    state_q, state_d;
  logic          scl_rise;
  logic          stalled;
  logic          no_retry_left;
  logic [DW-1:0] dwell;
  logic          bump, clear;

  sup_scl_rise #(.SYNC_STAGES(SYNC_STAGES)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_in),
    .rise   (scl_rise)
  );

  sup_stall_timer #(.LIMIT(TIMEOUT_CYC)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_WATCH),
    .kick    (scl_rise),
    .expired (stalled)
  );

  sup_dwell_timer #(.W(DW)) u_dwell (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .count   (dwell)
  );

  sup_fail_counter #(.MAX_RETRY(MAX_RETRY)) u_fails (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump      (bump),
    .clear     (clear),
    .exhausted (no_retry_left)
  );

  assign bump  = (state_q == ST_WATCH) && !xfer_done && stalled;
  assign clear = ((state_q == ST_WATCH) && xfer_done) ||
                 ((state_q == ST_DEAD)  && fail_clr);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (xfer_busy) state_d = ST_WATCH;
      ST_WATCH: begin
        if (xfer_done)       state_d = ST_IDLE;
        else if (stalled)    state_d = ST_FLOAT;
        else if (!xfer_busy) state_d = ST_IDLE;
      end
      ST_FLOAT:   state_d = ST_PWR_OFF;
      ST_PWR_OFF: if (dwell == OFF_LAST)    state_d = ST_SETTLE;
      ST_SETTLE:  if (dwell == SETTLE_LAST) state_d = ST_RETRY;
      ST_RETRY:   state_d = no_retry_left ? ST_DEAD : ST_WATCH;
      ST_DEAD:    if (fail_clr) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    pins_hiz     = 1'b0;
    slave_pwr_en = 1'b1;
    retry_req    = 1'b0;
    dev_dead     = 1'b0;
    unique case (state_q)
      ST_FLOAT, ST_SETTLE: pins_hiz = 1'b1;
      ST_PWR_OFF: begin
        pins_hiz     = 1'b1;
        slave_pwr_en = 1'b0;
      end
      ST_RETRY: begin
        pins_hiz  = no_retry_left;
        retry_req = !no_retry_left;
      end
      ST_DEAD: begin
        pins_hiz     = 1'b1;
        slave_pwr_en = 1'b0;
        dev_dead     = 1'b1;
      end
      default: ;
    endcase
  end

  AST_FLOAT_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slave_pwr_en) |-> $past(pins_hiz)); // R3

  AST_OFF_IMPLIES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_pwr_en |-> pins_hiz); // R3

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req); // R5

  AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (!pins_hiz && slave_pwr_en && !dev_dead)); // R5

  AST_DEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_dead && !fail_clr) |=> dev_dead); // R7

  AST_DEAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_dead) |-> ($past(pins_hiz) && !$past(retry_req))); // R6

  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH && xfer_done) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: tb/test_i2c_pwr_retry_sup.sv
module test_i2c_pwr_retry_sup;

  localparam int CLK_PERIOD = 10;
  localparam int T_TMO = 8;
  localparam int T_OFF = 5;
  localparam int T_SET = 4;
  localparam int N_RET = 2;

  // {scl rise gap (0 = none), cycles before done, expect timeout}
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{
    '{3, 40, 0},
    '{5, 30, 0},
    '{8, 30, 0},   // rise in the last cycle of the window
    '{9,  0, 1},   // rise one cycle too late
    '{0,  0, 1}    // SCL held low
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, done = 1'b0, scl = 1'b0, clr = 1'b0;
  logic hiz, pwr, req, dead;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pwr_retry_sup #(
    .TIMEOUT_CYC(T_TMO), .OFF_CYC(T_OFF), .SETTLE_CYC(T_SET), .MAX_RETRY(N_RET)
  ) i_i2c_pwr_retry_sup (
    .clk(clk), .rst_n(rst_n), .xfer_busy(busy), .xfer_done(done),
    .scl_in(scl), .fail_clr(clr), .pins_hiz(hiz), .slave_pwr_en(pwr),
    .retry_req(req), .dev_dead(dead)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input int e_hiz, input int e_pwr,
                      input int e_req, input int e_dead);
    check({tag, " pins_hiz"}, hiz, e_hiz);
    check({tag, " slave_pwr_en"}, pwr, e_pwr);
    check({tag, " retry_req"}, req, e_req);
    check({tag, " dev_dead"}, dead, e_dead);
  endtask

  // called at a falling edge in idle or retry; ends in the float cycle
  task automatic run_timeout();
    busy = 1'b1; scl = 1'b0;
    for (int c = 0; c < T_TMO; c++) begin
      @(negedge clk);
      outs("R2 watching", 0, 1, 0, 0);
    end
    @(negedge clk);
    outs("R3 float before power off", 1, 1, 0, 0);
    busy = 1'b0;
  endtask

  // from the float cycle to the retry cycle (or into failure)
  task automatic power_cycle(input bit last);
    for (int c = 0; c < T_OFF; c++) begin
      @(negedge clk);
      outs("R4 power off window", 1, 0, 0, 0);
    end
    for (int c = 0; c < T_SET; c++) begin
      @(negedge clk);
      outs("R4 settle window", 1, 1, 0, 0);
    end
    @(negedge clk);
    if (!last) outs("R5 retry pulse", 0, 1, 1, 0);
    else begin
      outs("R6 no retry when spent", 1, 1, 0, 0);
      @(negedge clk);
      outs("R6 failed state", 1, 0, 0, 1);
    end
  endtask

  // from a retry cycle: finish the rerun transfer successfully
  task automatic finish_ok();
    busy = 1'b1; done = 1'b0;
    @(negedge clk);
    check("R5 pulse single", req, 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0; busy = 1'b0;
    outs("R8 done returns idle", 0, 1, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge clk);
    outs("R1 in reset", 0, 1, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R1 after reset", 0, 1, 0, 0);

    // table of SCL progress patterns
    for (int v = 0; v < NVEC; v++) begin
      int gap, len, tmo;
      gap = VEC[v][0]; len = VEC[v][1]; tmo = VEC[v][2];
      busy = 1'b1; scl = 1'b0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (tmo != 0 && c == T_TMO) begin
          outs("R2 timeout seen", 1, 1, 0, 0);
          break;
        end
        check("R2 no early timeout", hiz, 0);
        if (tmo == 0 && c == len) begin
          scl = 1'b0; done = 1'b1;
          break;
        end
        scl = (gap > 0 && ((c + 1) % gap) == 0);
      end
      if (tmo != 0) begin
        busy = 1'b0; scl = 1'b0;
        power_cycle(1'b0);
        finish_ok();
      end else begin
        @(negedge clk);
        done = 1'b0; busy = 1'b0;
        outs("R8 progressing transfer ends idle", 0, 1, 0, 0);
      end
    end

    // R6: spend all retries, then fail
    run_timeout(); power_cycle(1'b0);
    run_timeout(); power_cycle(1'b0);
    run_timeout(); power_cycle(1'b1);

    // R7: failed state ignores traffic
    busy = 1'b1;
    for (int c = 0; c < 20; c++) begin
      done = (c % 3 == 0);
      scl  = (c % 2 == 0);
      @(negedge clk);
      outs("R7 sticky failure", 1, 0, 0, 1);
    end
    busy = 1'b0; done = 1'b0; scl = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    outs("R7 clear returns idle", 0, 1, 0, 0);
    run_timeout(); power_cycle(1'b0);   // count was cleared: retry again
    finish_ok();

    // R8: success clears the count
    run_timeout(); power_cycle(1'b0);
    run_timeout(); power_cycle(1'b0);
    finish_ok();
    run_timeout(); power_cycle(1'b0);   // would fail if count survived
    finish_ok();

    // R8: done in the last window cycle beats the timeout
    busy = 1'b1; scl = 1'b0;
    for (int c = 0; c < T_TMO; c++) begin
      @(negedge clk);
      if (c == T_TMO - 1) done = 1'b1;
    end
    @(negedge clk);
    done = 1'b0; busy = 1'b0;
    outs("R8 done beats timeout", 0, 1, 0, 0);

    // R1: asynchronous reset during power-off
    run_timeout();
    @(negedge clk);
    @(negedge clk);
    check("R1 powered off before reset", pwr, 0);
    rst_n = 1'b0;
    #1;
    outs("R1 reset mid recovery", 0, 1, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R1 idle after reset", 0, 1, 0, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule